// File: doc/BRIEF.md
# Video Capture Frame Controller

This block controls one video capture channel. It runs on the pixel clock and watches a vertical sync input together with horizontal and vertical valid qualifiers. For every accepted pixel it produces a storage write strobe and the address that pixel must be stored at. A DMA engine or memory controller downstream consumes that address. Software programs the channel through a small write-only register port.

All configuration except the channel enable goes into staging registers. The staged values are copied into the working set on each falling edge of vertical sync. Software can therefore prepare frame N+1 while frame N is being received. The enable bit is not staged and acts on the next clock.

At every frame start the block latches the width and height it measured during the frame that just ended, together with a flag that shows whether line widths differed within that frame. It also sets a sticky frame interrupt. In raw mode the programmed window sizes are ignored and every valid pixel is stored. In normal mode only pixels inside the programmed window are stored.

Top module: `vcap_frame_ctrl`

## Requirements
- R1: After reset, chanOn, pixWrite, pixAddr, frameIrq, irqPending, measWidth, measHeight and widthMismatch are all zero.
- R2: Writes to register index 1 (base), 2 (line offset), 3 (window width), 4 (window height) and to bit 1 of index 0 (raw mode) reach the working set only on a falling edge of vsync. A frame that is in progress keeps the values committed at its own start.
- R3: Bit 0 of register index 0 is the channel enable and takes effect on the clock edge of the write. Once it is cleared, no further pixel is written and a vsync falling edge does not set the interrupt.
- R4: A pixel sampled with hValid and vValid both high, at column c of line l, causes pixWrite one clock later with pixAddr = base + l*lineOffset + c, truncated to the address width.
- R5: In normal mode (raw bit 0), a pixel is written only when c < window width and l < window height.
- R6: In raw mode (raw bit 1), the window width and height are ignored and every valid pixel is written.
- R7: On each vsync falling edge, measWidth takes the pixel count of the first line of the frame that ended, and measHeight takes its number of lines.
- R8: On each vsync falling edge, widthMismatch goes to 1 if any line of the ended frame had a pixel count different from its first line, and to 0 otherwise.
- R9: A vsync falling edge while enabled sets irqPending. It stays set until bit 0 is written as 1 to register index 7. Every write of the frame before it has already appeared when it is set.
- R10: frameIrq equals irqPending gated by an interrupt enable. Writing 1 in bit 0 of index 5 sets that enable, and writing 1 in bit 0 of index 6 clears it.
- R11: Clearing the channel enable leaves the committed configuration and the line position untouched. Re-enabling within a frame continues with the same base and line offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical sync; falling edge marks frame start |
| hValid | input | 1 | Horizontal valid qualifier |
| vValid | input | 1 | Vertical valid qualifier |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register index |
| wrData | input | ADDR_W | Register write data |
| chanOn | output | 1 | Current channel enable |
| pixWrite | output | 1 | Storage write strobe for one pixel |
| pixAddr | output | ADDR_W | Storage address of that pixel |
| frameIrq | output | 1 | Gated frame interrupt |
| irqPending | output | 1 | Sticky interrupt status |
| measWidth | output | DIM_W | Measured width of previous frame |
| measHeight | output | DIM_W | Measured line count of previous frame |
| widthMismatch | output | 1 | Previous frame had unequal line widths |

## Verification
The bench sweeps 24 frames that cover every line width from 1 to 4 and every line count from 1 to 3, in both normal and raw mode. The window size, base and line offset change on every frame. The next frame's configuration is written in the middle of the current frame, so any address that leaks a staged value shows up as a mismatch against the arithmetic model. The clipped normal-mode frames, set against the unclipped raw frames, separate window gating from mode selection. Directed sequences then cover four more cases: a frame with one wider line, which must raise the mismatch flag, followed by a uniform frame, which must clear it; an enable dropped in the middle of a line and restored; a frame edge seen while disabled; and the interrupt enable being toggled around a pending status.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_BASE    = 3'd1,
    REG_LOFF    = 3'd2,
    REG_HSIZE   = 3'd3,
    REG_VSIZE   = 3'd4,
    REG_IEN_SET = 3'd5,
    REG_IEN_CLR = 3'd6,
    REG_IST_CLR = 3'd7
  } regSel_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic frameStart;
    logic chanOn;
    logic rawMode;
  } ctlStrobe_t;

endpackage

// File: rtl/vcap_ctrl.sv
module vcap_ctrl
  import vcap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vsync,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [ADDR_W-1:0] wrData,
  output ctlStrobe_t        strobe,
  output logic [ADDR_W-1:0] actBase,
  output logic [ADDR_W-1:0] actLoff,
  output logic [DIM_W-1:0]  actHSize,
  output logic [DIM_W-1:0]  actVSize,
  output logic              chanOn,
  output logic              irqPending,
  output logic              frameIrq
);

  regSel_e sel;
  logic vsyncD;
  logic frameFall;
  logic stgRaw, actRaw;
  logic [ADDR_W-1:0] stgBase, stgLoff;
  logic [DIM_W-1:0]  stgHSize, stgVSize;
  logic irqEn;
  logic statClr;

  assign sel       = regSel_e'(wrAddr);
  assign frameFall = vsyncD & ~vsync;
  assign statClr   = wrEn && (sel == REG_IST_CLR) && wrData[0];

  // staging side and immediate enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanOn   <= 1'b0;
      stgRaw   <= 1'b0;
      stgBase  <= '0;
      stgLoff  <= '0;
      stgHSize <= '0;
      stgVSize <= '0;
      irqEn    <= 1'b0;
    end else if (wrEn) begin
      case (sel)
        REG_CTRL: begin
          chanOn <= wrData[0];
          stgRaw <= wrData[1];
        end
        REG_BASE:    stgBase  <= wrData;
        REG_LOFF:    stgLoff  <= wrData;
        REG_HSIZE:   stgHSize <= wrData[DIM_W-1:0];
        REG_VSIZE:   stgVSize <= wrData[DIM_W-1:0];
        REG_IEN_SET: if (wrData[0]) irqEn <= 1'b1;
        REG_IEN_CLR: if (wrData[0]) irqEn <= 1'b0;
        default: ;
      endcase
    end
  end

  // commit at frame boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vsyncD   <= 1'b0;
      actRaw   <= 1'b0;
      actBase  <= '0;
      actLoff  <= '0;
      actHSize <= '0;
      actVSize <= '0;
    end else begin
      vsyncD <= vsync;
      if (frameFall) begin
        actRaw   <= stgRaw;
        actBase  <= stgBase;
        actLoff  <= stgLoff;
        actHSize <= stgHSize;
        actVSize <= stgVSize;
      end
    end
  end

  // sticky frame interrupt; a new frame wins over a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else if (frameFall && chanOn) begin
      irqPending <= 1'b1;
    end else if (statClr) begin
      irqPending <= 1'b0;
    end
  end

  assign frameIrq          = irqPending & irqEn;
  assign strobe.frameStart = frameFall;
  assign strobe.chanOn     = chanOn;
  assign strobe.rawMode    = actRaw;

endmodule

// File: rtl/vcap_datapath.sv
module vcap_datapath
  import vcap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hValid,
  input  logic              vValid,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] actBase,
  input  logic [ADDR_W-1:0] actLoff,
  input  logic [DIM_W-1:0]  actHSize,
  input  logic [DIM_W-1:0]  actVSize,
  output logic              pixWrite,
  output logic [ADDR_W-1:0] pixAddr,
  output logic [DIM_W-1:0]  measWidth,
  output logic [DIM_W-1:0]  measHeight,
  output logic              widthMismatch
);

  logic pixel, pixelD, lineEnd, inWindow, accept;
  logic [DIM_W-1:0] colCnt, lineCnt, firstWidth;
  logic mismatchCur;
  logic [ADDR_W-1:0] lineBase, nextAddr;

  assign pixel    = hValid & vValid;
  assign lineEnd  = pixelD & ~pixel & (colCnt != '0);
  assign inWindow = (colCnt < actHSize) && (lineCnt < actVSize);
  assign accept   = strobe.rawMode | inWindow;
  assign lineBase = actBase + ADDR_W'(lineCnt) * actLoff;
  assign nextAddr = lineBase + ADDR_W'(colCnt);

  // pixel and line position counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixelD      <= 1'b0;
      colCnt      <= '0;
      lineCnt     <= '0;
      firstWidth  <= '0;
      mismatchCur <= 1'b0;
    end else begin
      pixelD <= pixel;
      if (strobe.frameStart) begin
        colCnt      <= '0;
        lineCnt     <= '0;
        firstWidth  <= '0;
        mismatchCur <= 1'b0;
      end else if (pixel) begin
        colCnt <= colCnt + 1'b1;
      end else if (lineEnd) begin
        colCnt  <= '0;
        lineCnt <= lineCnt + 1'b1;
        if (lineCnt == '0) begin
          firstWidth <= colCnt;
        end else if (colCnt != firstWidth) begin
          mismatchCur <= 1'b1;
        end
      end
    end
  end

  // frame-level measurement latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      measWidth     <= '0;
      measHeight    <= '0;
      widthMismatch <= 1'b0;
    end else if (strobe.frameStart) begin
      measWidth     <= firstWidth;
      measHeight    <= lineCnt;
      widthMismatch <= mismatchCur;
    end
  end

  // storage write request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixWrite <= 1'b0;
      pixAddr  <= '0;
    end else begin
      pixWrite <= strobe.chanOn & pixel & accept & ~strobe.frameStart;
      if (strobe.chanOn && pixel && accept) begin
        pixAddr <= nextAddr;
      end
    end
  end

endmodule

// File: rtl/vcap_frame_ctrl.sv
module vcap_frame_ctrl
  import vcap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vsync,
  input  logic              hValid,
  input  logic              vValid,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [ADDR_W-1:0] wrData,
  output logic              chanOn,
  output logic              pixWrite,
  output logic [ADDR_W-1:0] pixAddr,
  output logic              frameIrq,
  output logic              irqPending,
  output logic [DIM_W-1:0]  measWidth,
  output logic [DIM_W-1:0]  measHeight,
  output logic              widthMismatch
);

  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] actBase, actLoff;
  logic [DIM_W-1:0]  actHSize, actVSize;

  vcap_ctrl #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .vsync(vsync),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .actBase(actBase), .actLoff(actLoff),
    .actHSize(actHSize), .actVSize(actVSize),
    .chanOn(chanOn), .irqPending(irqPending), .frameIrq(frameIrq)
  );

  vcap_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uData (
    .clk(clk), .rstN(rstN), .hValid(hValid), .vValid(vValid),
    .strobe(strobe), .actBase(actBase), .actLoff(actLoff),
    .actHSize(actHSize), .actVSize(actVSize),
    .pixWrite(pixWrite), .pixAddr(pixAddr),
    .measWidth(measWidth), .measHeight(measHeight),
    .widthMismatch(widthMismatch)
  );

endmodule

// File: rtl/vcap_frame_ctrl_chk.sv
module vcap_frame_ctrl_chk
  import vcap_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       vsync,
  input logic       hValid,
  input logic       vValid,
  input logic       wrEn,
  input logic [2:0] wrAddr,
  input logic       wrBit0,
  input logic       chanOn,
  input logic       pixWrite,
  input logic       irqPending,
  input logic       frameIrq
);

  AST_PIX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    pixWrite |-> $past(chanOn)); // R3

  AST_ENABLE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && wrAddr == REG_CTRL) |-> (chanOn == $past(wrBit0))); // R3

  AST_PIX_FROM_VALID: assert property (@(posedge clk) disable iff (!rstN)
    pixWrite |-> $past(hValid && vValid)); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqPending) && !$past(wrEn && wrAddr == REG_IST_CLR && wrBit0)) |-> irqPending); // R9

  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> (!$past(vsync) && $past(vsync, 2) && $past(chanOn))); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |-> irqPending); // R10

endmodule

bind vcap_frame_ctrl vcap_frame_ctrl_chk chk (
  .clk(clk), .rstN(rstN), .vsync(vsync), .hValid(hValid), .vValid(vValid),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrBit0(wrData[0]), .chanOn(chanOn),
  .pixWrite(pixWrite), .irqPending(irqPending), .frameIrq(frameIrq)
);

// File: tb/vcap_frame_ctrl_test.sv
`timescale 1ns/1ps
module vcap_frame_ctrl_test;

  localparam int ADDR_W = 16;
  localparam int DIM_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vsync = 1'b0, hValid = 1'b0, vValid = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [ADDR_W-1:0] wrData = '0;
  logic chanOn, pixWrite, frameIrq, irqPending, widthMismatch;
  logic [ADDR_W-1:0] pixAddr;
  logic [DIM_W-1:0] measWidth, measHeight;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  logic [ADDR_W-1:0] got [0:255];
  int gotN = 0;
  logic [ADDR_W-1:0] expA [0:255];
  int expN;

  always #4 clk = ~clk;

  vcap_frame_ctrl #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uut (
    .clk(clk), .rstN(rstN), .vsync(vsync), .hValid(hValid), .vValid(vValid),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .chanOn(chanOn),
    .pixWrite(pixWrite), .pixAddr(pixAddr), .frameIrq(frameIrq),
    .irqPending(irqPending), .measWidth(measWidth), .measHeight(measHeight),
    .widthMismatch(widthMismatch)
  );

  // write monitor
  always @(posedge clk) begin
    #2;
    if (pixWrite && gotN < 256) begin
      got[gotN] = pixAddr;
      gotN++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input int idx, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = idx[2:0]; wrData = data[ADDR_W-1:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic vsyncPulse();
    @(negedge clk); hValid = 0; vValid = 0; vsync = 1;
    @(negedge clk);
    @(negedge clk); vsync = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendLine(input int w);
    @(negedge clk); vValid = 1;
    for (int i = 0; i < w; i++) begin
      hValid = 1;
      @(negedge clk);
    end
    hValid = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int cfgRaw(input int k);  return (k / 12) % 2; endfunction
  function automatic int cfgBase(input int k); return 256 + k * 37; endfunction
  function automatic int cfgLoff(input int k); return 5 + k % 3; endfunction
  function automatic int cfgH(input int k);    return 1 + (k + 1) % 4; endfunction
  function automatic int cfgV(input int k);    return 1 + (k + 2) % 3; endfunction

  task automatic writeCfg(input int k);
    wrReg(0, cfgRaw(k) * 2 + 1);
    wrReg(1, cfgBase(k));
    wrReg(2, cfgLoff(k));
    wrReg(3, cfgH(k));
    wrReg(4, cfgV(k));
  endtask

  task automatic checkIrqAndClear(input string req);
    check(irqPending == 1'b1, req, "irqPending after frame edge", irqPending, 1);
    check(frameIrq == 1'b1, req, "frameIrq after frame edge", frameIrq, 1);
    wrReg(7, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int w, h, pw, ph, bad;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({chanOn, pixWrite, frameIrq, irqPending, widthMismatch} == 5'b0,
          "R1", "control outputs", {chanOn, pixWrite, frameIrq, irqPending, widthMismatch}, 0);
    check(pixAddr == 0 && measWidth == 0 && measHeight == 0,
          "R1", "data outputs", pixAddr + measWidth + measHeight, 0);

    wrReg(5, 1);
    writeCfg(0);
    pw = 0; ph = 0;
    // sweep: next frame's config written mid-frame (R2)
    for (int k = 0; k < 24; k++) begin
      vsyncPulse();
      if (k > 0) begin
        check(measWidth == pw, "R7", "measured width", measWidth, pw);
        check(measHeight == ph, "R7", "measured height", measHeight, ph);
        check(widthMismatch == 0, "R8", "uniform frame flag", widthMismatch, 0);
      end
      checkIrqAndClear("R9");
      gotN = 0;
      w = 1 + k % 4;
      h = 1 + (k / 4) % 3;
      sendLine(w);
      writeCfg(k + 1);
      for (int l = 1; l < h; l++) sendLine(w);
      vValid = 0;
      repeat (3) @(negedge clk);
      expN = 0;
      for (int l = 0; l < h; l++)
        for (int c = 0; c < w; c++)
          if (cfgRaw(k) == 1 || (c < cfgH(k) && l < cfgV(k))) begin
            expA[expN] = ADDR_W'(cfgBase(k) + l * cfgLoff(k) + c);
            expN++;
          end
      check(gotN == expN, cfgRaw(k) ? "R6" : "R5", "write count", gotN, expN);
      bad = 0;
      for (int i = 0; i < expN && i < gotN; i++)
        if (got[i] != expA[i]) begin
          bad++;
          $display("FAIL R2 R4 frame %0d write %0d: actual %0d expected %0d",
                   k, i, got[i], expA[i]);
        end
      check(bad == 0, "R4", "address sequence", bad, 0);
      pw = w; ph = h;
    end
    vsyncPulse();
    check(measWidth == pw && measHeight == ph, "R7", "last sweep frame size",
          measWidth * 256 + measHeight, pw * 256 + ph);
    checkIrqAndClear("R9");

    // R8 mismatch frame
    sendLine(3); sendLine(5); sendLine(3);
    vValid = 0;
    vsyncPulse();
    check(widthMismatch == 1, "R8", "mismatch flag set", widthMismatch, 1);
    check(measWidth == 3 && measHeight == 3, "R7", "mismatch frame size",
          measWidth * 256 + measHeight, 3 * 256 + 3);
    checkIrqAndClear("R9");
    sendLine(2); sendLine(2);
    vValid = 0;
    vsyncPulse();
    check(widthMismatch == 0, "R8", "mismatch flag cleared", widthMismatch, 0);
    check(measWidth == 2 && measHeight == 2, "R7", "uniform frame size",
          measWidth * 256 + measHeight, 2 * 256 + 2);
    checkIrqAndClear("R9");

    // R3 / R11 enable dropped mid-line and restored
    wrReg(0, 3); wrReg(1, 16'h40); wrReg(2, 16);
    vsyncPulse();
    wrReg(7, 1);
    gotN = 0;
    @(negedge clk); vValid = 1; hValid = 1;
    @(negedge clk);
    @(negedge clk); wrEn = 1; wrAddr = 3'd0; wrData = 16'd2;
    @(negedge clk); wrEn = 0;
    @(negedge clk);
    @(negedge clk); hValid = 0;
    repeat (3) @(negedge clk);
    check(gotN == 3, "R3", "writes before disable", gotN, 3);
    check(got[0] == 16'h40 && got[1] == 16'h41 && got[2] == 16'h42, "R3",
          "addresses before disable", got[2], 16'h42);
    check(chanOn == 0, "R3", "chanOn after clear", chanOn, 0);
    wrReg(0, 3);
    check(chanOn == 1, "R3", "chanOn after set", chanOn, 1);
    sendLine(2);
    vValid = 0;
    check(gotN == 5, "R11", "writes after re-enable", gotN, 5);
    check(got[3] == 16'h50 && got[4] == 16'h51, "R11", "re-enable address",
          got[3], 16'h50);
    wrReg(0, 2);
    vsyncPulse();
    check(irqPending == 0, "R3", "no interrupt while disabled", irqPending, 0);
    wrReg(0, 3);

    // R10 interrupt enable strobes
    wrReg(6, 1);
    vsyncPulse();
    check(irqPending == 1 && frameIrq == 0, "R10", "masked interrupt",
          frameIrq, 0);
    wrReg(5, 1);
    check(frameIrq == 1, "R10", "unmasked interrupt", frameIrq, 1);
    repeat (4) @(negedge clk);
    check(irqPending == 1, "R9", "status sticky", irqPending, 1);
    wrReg(7, 1);
    check(irqPending == 0 && frameIrq == 0, "R9", "status cleared",
          irqPending, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule